// File: doc/BRIEF.md
# Pattern-Fill Page Engine

This engine writes a short repeating bit pattern over a range of memory pages, so that a bulk update of packed state can run without a processor storing each word itself. The requester keeps smaller updates to itself and hands a range to the engine only when the range spans more than one page. It programs a base page number, a page count, a pattern and a pattern width through a small register port, then writes the start bit and can suspend itself. The engine issues one 64-bit write per accepted valid/ready handshake, with addresses rising by 8 bytes through every 4 KB page of the range. After the last write has been accepted it raises an interrupt, and the interrupt stays up until the requester clears it.

The pattern is 1, 2, 4, 8, 16, 32 or 64 bits wide. It is copied across each 64-bit word, and the same word is written to every location of the range. The engine takes a copy of the configuration when it starts. Writes to the configuration registers while a fill is running therefore only affect the next fill.

Top module: `pfill_dma`

## Requirements
- R1: After reset, mem_valid and irq are low, and the status register (read offset 5) reads zero.
- R2: A start with a page count N greater than zero produces exactly N*512 accepted writes. The first address is base_page*4096, and each following address is 8 bytes higher. No write is offered after the last one.
- R3: Each written word is the pattern copied across 64 bits. Width code w (register offset 4, bits 2:0) selects 2^w pattern bits for w from 0 to 5; codes 6 and 7 select all 64 bits. Word bit i equals pattern bit (i mod width).
- R4: While mem_valid is high and mem_ready is low, mem_addr and mem_data hold their values. A write counts as accepted on a clock edge where both mem_valid and mem_ready are high.
- R5: In the cycle after the last write is accepted, irq is high and the busy flag is low.
- R6: irq stays high until a register write to offset 0 with bit 1 set, and it is low in the cycle after that write.
- R7: A start (offset 0, bit 0) written while busy is ignored. Changes to the pattern or the count made during a fill do not alter that fill's addresses, data or length.
- R8: A start with a page count of zero offers no write, and irq is high in the following cycle.
- R9: The status register (offset 5) holds busy in bit 0, irq in bit 1, and the number of pages not yet finished in bits 16 and up. The current page counts as not finished.
- R10: Offsets 1 (base page), 2 (page count), 3 (pattern) and 4 (width code) read back the last value written, truncated to the field width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_raddr | input | 3 | Register read offset |
| cfg_rdata | output | 64 | Register read data (combinational) |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_data | output | 64 | Write data |
| irq | output | 1 | Fill-complete interrupt, cleared by software |

## Verification
A corrupted word or page counter shows up at the ports as an address that breaks the +8 sequence, or as the engine ending too early or too late. The address check catches it at the first bad handshake, and the remaining-page field in status catches it within one cycle. A wrong copied pattern shows in the data of the very first write. A lost or spurious completion shows in irq and busy one cycle after the last handshake. Starts and configuration writes issued in the middle of a fill expose any leak from live registers into the running fill, because the next handshake would then carry the wrong data or the total write count would change.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int DW = 64;
  localparam int RAW = 3;

  localparam logic [RAW-1:0] OFS_CTRL  = 3'd0;
  localparam logic [RAW-1:0] OFS_BASE  = 3'd1;
  localparam logic [RAW-1:0] OFS_COUNT = 3'd2;
  localparam logic [RAW-1:0] OFS_PAT   = 3'd3;
  localparam logic [RAW-1:0] OFS_WIDTH = 3'd4;
  localparam logic [RAW-1:0] OFS_STAT  = 3'd5;

  localparam int STAT_LEFT_LSB = 16;

  typedef enum logic {S_IDLE, S_RUN} fill_state_e;
endpackage

// File: rtl/pfd_regs.sv
module pfd_regs
  import pfd_pkg::*;
#(
  parameter int PAGE_W = 28,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RAW-1:0]    waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [RAW-1:0]    raddr,
  output logic [DW-1:0]     rdata,
  input  logic              busy,
  input  logic              irq,
  input  logic [CNT_W-1:0]  pages_left,
  output logic [PAGE_W-1:0] base_page,
  output logic [CNT_W-1:0]  page_cnt,
  output logic [DW-1:0]     pattern,
  output logic [2:0]        wcode,
  output logic              start_p,
  output logic              clr_p
);
  logic base_en, cnt_en, pat_en, wc_en;

  always_comb begin
    base_en = we && (waddr == OFS_BASE);
    cnt_en  = we && (waddr == OFS_COUNT);
    pat_en  = we && (waddr == OFS_PAT);
    wc_en   = we && (waddr == OFS_WIDTH);
    start_p = we && (waddr == OFS_CTRL) && wdata[0];
    clr_p   = we && (waddr == OFS_CTRL) && wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_page <= '0;
      page_cnt  <= '0;
      pattern   <= '0;
      wcode     <= '0;
    end else begin
      if (base_en) base_page <= wdata[PAGE_W-1:0];
      if (cnt_en)  page_cnt  <= wdata[CNT_W-1:0];
      if (pat_en)  pattern   <= wdata;
      if (wc_en)   wcode     <= wdata[2:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (raddr)
      OFS_BASE:  rdata[PAGE_W-1:0] = base_page;
      OFS_COUNT: rdata[CNT_W-1:0]  = page_cnt;
      OFS_PAT:   rdata             = pattern;
      OFS_WIDTH: rdata[2:0]        = wcode;
      OFS_STAT: begin
        rdata[0] = busy;
        rdata[1] = irq;
        rdata[STAT_LEFT_LSB +: CNT_W] = pages_left;
      end
      default: rdata = '0;
    endcase
  end

  // R10: a written field is visible on the next cycle
  a_r10_count_wr: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> page_cnt == $past(wdata[CNT_W-1:0]));
endmodule

// File: rtl/pfd_rep.sv
module pfd_rep
  import pfd_pkg::*;
(
  input  logic [DW-1:0] pattern,
  input  logic [2:0]    wcode,
  output logic [DW-1:0] word
);
  localparam int IW = $clog2(DW);
  logic [IW-1:0] mask;

  always_comb begin
    if (wcode >= 3'd6) mask = '1;
    else               mask = IW'((1 << wcode) - 1);
  end

  for (genvar i = 0; i < DW; i++) begin : g_bit
    localparam logic [IW-1:0] IDX = IW'(i);
    assign word[i] = pattern[IDX & mask];
  end
endmodule

// File: rtl/pfd_seq.sv
module pfd_seq
  import pfd_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_p,
  input  logic                          clr_p,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] base_page,
  input  logic [CNT_W-1:0]              page_cnt,
  input  logic [DW-1:0]                 fill_word,
  input  logic                          mem_ready,
  output logic                          mem_valid,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [DW-1:0]                 mem_data,
  output logic                          busy,
  output logic                          irq,
  output logic [CNT_W-1:0]              pages_left
);
  localparam int WORD_BYTES = DW / 8;
  localparam int WPP        = PAGE_BYTES / WORD_BYTES;
  localparam int WCW        = $clog2(WPP);
  localparam int PG_SHIFT   = $clog2(PAGE_BYTES);

  fill_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WCW-1:0]   word_q, word_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [DW-1:0]    data_q;
  logic             irq_q, irq_d;
  logic             hs, last_word, last, load, adv;

  always_comb begin
    hs        = (state_q == S_RUN) && mem_ready;
    last_word = (word_q == WCW'(WPP - 1));
    last      = hs && last_word && (left_q == CNT_W'(1));
    load      = (state_q == S_IDLE) && start_p && (page_cnt != '0);
    adv       = hs;

    state_d = state_q;
    addr_d  = addr_q;
    word_d  = word_q;
    left_d  = left_q;
    irq_d   = clr_p ? 1'b0 : irq_q;

    if (state_q == S_IDLE) begin
      if (start_p) begin
        if (page_cnt == '0) begin
          irq_d = 1'b1;
        end else begin
          state_d = S_RUN;
          addr_d  = {base_page, {PG_SHIFT{1'b0}}};
          word_d  = '0;
          left_d  = page_cnt;
        end
      end
    end else if (hs) begin
      addr_d = addr_q + ADDR_W'(WORD_BYTES);
      word_d = last_word ? '0 : word_q + 1'b1;
      if (last_word) left_d = left_q - 1'b1;
      if (last) begin
        state_d = S_IDLE;
        irq_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      word_q  <= '0;
      left_q  <= '0;
      data_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      if (load || adv) begin
        addr_q <= addr_d;
        word_q <= word_d;
        left_q <= left_d;
      end
      if (load) data_q <= fill_word;
    end
  end

  assign mem_valid  = (state_q == S_RUN);
  assign busy       = (state_q == S_RUN);
  assign mem_addr   = addr_q;
  assign mem_data   = data_q;
  assign irq        = irq_q;
  assign pages_left = left_q;

  // R4: an offered write holds until accepted
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R2: consecutive writes step by one word
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !last |=> mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES));
  // R5: the interrupt only rises after a final handshake or an empty start
  a_r5_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(last) || $past(start_p));
  // R6: the interrupt is sticky until cleared
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_p |=> irq);
  // R7: a start during a fill does not disturb it
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_p && !hs |=> busy && $stable(mem_addr) && $stable(pages_left));
  // R8: an empty range completes at once with no write
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start_p && page_cnt == '0 |=> irq && !mem_valid);
  // R9: a running fill always has a page left
  a_r9_left: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pages_left != '0);
endmodule

// File: rtl/pfill_dma.sv
module pfill_dma
  import pfd_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_waddr,
  input  logic [63:0]       cfg_wdata,
  input  logic [2:0]        cfg_raddr,
  output logic [63:0]       cfg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_data,
  output logic              irq
);
  localparam int PAGE_W = ADDR_W - $clog2(PAGE_BYTES);

  logic [PAGE_W-1:0] base_page;
  logic [CNT_W-1:0]  page_cnt, pages_left;
  logic [DW-1:0]     pattern, fill_word;
  logic [2:0]        wcode;
  logic              start_p, clr_p, busy;

  pfd_regs #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .busy(busy), .irq(irq),
    .pages_left(pages_left), .base_page(base_page), .page_cnt(page_cnt),
    .pattern(pattern), .wcode(wcode), .start_p(start_p), .clr_p(clr_p)
  );

  pfd_rep u_rep (.pattern(pattern), .wcode(wcode), .word(fill_word));

  pfd_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .clr_p(clr_p),
    .base_page(base_page), .page_cnt(page_cnt), .fill_word(fill_word),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .irq(irq), .pages_left(pages_left)
  );
endmodule

// File: tb/sim_pfill_dma.sv
module sim_pfill_dma;
  localparam int AW  = 40;
  localparam int WPP = 512;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [2:0] cfg_waddr, cfg_raddr;
  logic [63:0] cfg_wdata, cfg_rdata;
  logic mem_valid, mem_ready, irq;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pfill_dma u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rep_word(input logic [63:0] pat, input int w);
    int n = (w >= 6) ? 64 : (1 << w);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = pat[i % n];
    return r;
  endfunction

  // called at a negedge, returns at the next negedge with the strobe dropped
  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    cfg_raddr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic run_fill(input logic [27:0] base, input int cnt, input logic [63:0] pat,
                          input int w, input bit inject);
    logic [63:0] v, expd;
    logic [AW-1:0] ea;
    int total = cnt * WPP;
    int hs_done = 0;
    bit pend = 0;
    int stage = 0;
    int guard = 0;
    expd = rep_word(pat, w);
    wr(3'd1, {36'd0, base});
    wr(3'd2, 64'(cnt));
    wr(3'd3, pat);
    wr(3'd4, 64'(w));
    rd(3'd1, v); chk(v == {36'd0, base}, "R10 base readback", v, {36'd0, base});
    rd(3'd2, v); chk(v == 64'(cnt), "R10 count readback", v, 64'(cnt));
    rd(3'd3, v); chk(v == pat, "R10 pattern readback", v, pat);
    rd(3'd4, v); chk(v == 64'(w & 7), "R10 width readback", v, 64'(w & 7));
    cfg_raddr = 3'd5;
    wr(3'd0, 64'd3);
    forever begin
      cfg_we = 1'b0;
      if (pend) begin hs_done++; pend = 0; end
      if (hs_done == total) begin
        chk(!mem_valid, "R2 no write after last", 64'(mem_valid), 64'd0);
        chk(irq, "R5 irq after last write", 64'(irq), 64'd1);
        rd(3'd5, v);
        chk(v == 64'd2, "R5 R9 status at completion", v, 64'd2);
        mem_ready = 1'b0;
        break;
      end
      rd(3'd5, v);
      chk(v == ((64'(cnt - hs_done / WPP) << 16) | 64'd1), "R9 status while busy", v,
          (64'(cnt - hs_done / WPP) << 16) | 64'd1);
      chk(mem_valid && !irq, "R2 valid during fill", {62'd0, mem_valid, irq}, 64'd2);
      mem_ready = ($urandom % 4) != 0;
      if (mem_ready && mem_valid) begin
        ea = (AW'(base) << 12) + AW'(hs_done) * AW'(8);
        chk(mem_addr == ea, "R2 R4 address", 64'(mem_addr), 64'(ea));
        chk(mem_data == expd, "R3 R7 data", mem_data, expd);
        pend = 1;
      end
      if (inject) begin
        if (stage == 0 && hs_done >= total / 2) begin
          cfg_we = 1'b1; cfg_waddr = 3'd3; cfg_wdata = ~pat; stage = 1;
        end else if (stage == 1) begin
          cfg_we = 1'b1; cfg_waddr = 3'd2; cfg_wdata = 64'd7; stage = 2;
        end else if (stage == 2) begin
          cfg_we = 1'b1; cfg_waddr = 3'd0; cfg_wdata = 64'd1; stage = 3;
        end
      end
      guard++;
      if (guard > 40000) begin
        chk(0, "R2 fill did not finish", 64'(hs_done), 64'(total));
        break;
      end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(irq, "R6 irq held", 64'(irq), 64'd1);
    chk(!mem_valid, "R7 no restart after fill", 64'(mem_valid), 64'd0);
    if (inject) begin
      rd(3'd2, v);
      chk(v == 64'd7, "R7 R10 count written during fill", v, 64'd7);
    end
    wr(3'd0, 64'd2);
    chk(!irq, "R6 irq cleared", 64'(irq), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_waddr = '0; cfg_wdata = '0; cfg_raddr = 3'd5;
    mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd5, v);
    chk(v == 64'd0, "R1 status after reset", v, 64'd0);
    chk(!mem_valid && !irq, "R1 outputs after reset", {62'd0, mem_valid, irq}, 64'd0);

    run_fill(28'd5, 1, 64'hA, 2, 0);
    run_fill(28'h0FFFFFF, 2, 64'h1, 0, 0);
    run_fill(28'd77, 1, 64'h0123_4567_89AB_CDEF, 7, 0);
    run_fill(28'd300, 2, 64'hDEAD_BEEF_F00D_CAFE, 6, 1);
    for (int t = 0; t < 4; t++) begin
      run_fill(28'($urandom), 1 + ($urandom % 2), {$urandom, $urandom}, int'($urandom % 8), 0);
    end

    // R8: empty range
    wr(3'd2, 64'd0);
    wr(3'd0, 64'd1);
    chk(irq && !mem_valid, "R8 zero count irq", {62'd0, mem_valid, irq}, 64'd1);
    rd(3'd5, v);
    chk(v == 64'd2, "R8 zero count status", v, 64'd2);
    repeat (5) @(negedge clk);
    chk(irq && !mem_valid, "R8 R6 zero count quiet", {62'd0, mem_valid, irq}, 64'd1);
    wr(3'd0, 64'd2);
    chk(!irq, "R6 clear after zero count", 64'(irq), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule